// File: doc/BRIEF.md
# DMA Engine Control and Status Register File

This block is the register file through which software brings up and runs a pair of DMA engines, one for receive and one for transmit. It holds the engine run bits, the base addresses of the two descriptor lists, an interrupt enable mask and an event status register. The engines themselves sit outside. They receive a reset level, two run levels and two base addresses from this block, and they return single-cycle event pulses.

Software reaches the registers through a plain word-addressed port. A write takes effect at the clock edge on which `wrEn` is sampled high. A read is combinational from `regAddr`. Setting the reset bit of the mode register starts an internal reset sequence of a fixed length. While it runs, every register is held at its reset value, writes are dropped and events are not recorded. The reset bit reads back as 1 until the sequence has finished.

Status bits are set by engine events and cleared by writing 1. Bit 16 of the status register is a summary: the OR of the status bits whose enable is set. The interrupt output follows the summary.

Top module: `dma_csr`

Register map (word index on `regAddr`):

| Index | Register |
|-------|----------|
| 0 | mode: bit 0 soft reset, bit 1 receive run, bit 13 transmit run |
| 1 | status: bits [NUM_EVT-1:0] events, bit 16 summary |
| 2 | interrupt enable: bits [NUM_EVT-1:0] |
| 3 | receive descriptor list base |
| 4 | transmit descriptor list base |

## Requirements
- R1: After `rstN` is released, every register reads 0, and `irq`, `engReset`, `rxRun` and `txRun` are 0.
- R2: Writing 1 to bit 0 of the mode register (index 0) raises `engReset`, and bit 0 of the mode register reads 1, for exactly RST_CYCLES clock cycles starting at the next edge. Both then return to 0, and every register reads 0 afterwards.
- R3: While the reset sequence runs, register writes have no effect and event pulses are not recorded. This includes the other bits of the write that started the sequence.
- R4: Bit 1 of a mode write sets `rxRun` and bit 13 sets `txRun`. Both read back at the same bit positions of index 0.
- R5: A pulse on `evtPulse[i]` with i < NUM_EVT sets status bit i (index 1) at the next edge. The bit stays set until software clears it. Status bits at and above NUM_EVT, other than bit 16, read 0.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: When an event pulse and a write-1 clear reach the same status bit on the same edge, the bit ends up set.
- R8: Status bit 16 reads 1 exactly when some status bit i is set and interrupt enable bit i is set. It is recomputed on the same edge as any status or enable change, so writing 1 to bit 16 does not hold it at 0 while enabled members remain set.
- R9: The interrupt enable register (index 2) stores bits [NUM_EVT-1:0]. `irq` equals status bit 16, and disabled events never raise it.
- R10: The receive base (index 3) and transmit base (index 4) accept writes only while `rxRun`, respectively `txRun`, is 0. Each drives its base output (`rxBase`, `txBase`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word index |
| wrEn | input | 1 | Write strobe, sampled at the clock edge |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `regAddr` |
| evtPulse | input | NUM_EVT | Single-cycle event pulses from the engines |
| irq | output | 1 | Interrupt request, equal to the status summary |
| engReset | output | 1 | Reset level to the engines during the reset sequence |
| rxRun | output | 1 | Receive engine run level |
| txRun | output | 1 | Transmit engine run level |
| rxBase | output | DATA_W | Receive descriptor list base address |
| txBase | output | DATA_W | Transmit descriptor list base address |

## Verification
The bench builds the block with DATA_W = 32, NUM_EVT = 6 and RST_CYCLES = 16. Six events leave bits 6 to 15 of the status and enable registers unimplemented, so writes of all ones show that those bits read 0 and never feed the summary. The full sixteen-cycle reset window is long enough to fit several write attempts and event pulses inside it. The bench counts the reset window edge by edge at both the port and the mode register read-back.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 3'd0,
    REG_STATUS = 3'd1,
    REG_INTEN  = 3'd2,
    REG_RXBASE = 3'd3,
    REG_TXBASE = 3'd4
  } regSel_e;

  localparam int BIT_RESET   = 0;
  localparam int BIT_RXRUN   = 1;
  localparam int BIT_TXRUN   = 13;
  localparam int BIT_SUMMARY = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrMode;
    logic wrStatus;
    logic wrIntEn;
    logic wrRxBase;
    logic wrTxBase;
    logic clear;   // force every register to its reset value at this edge
    logic busy;    // reset sequence in progress
  } csrStrobe_t;

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrResetBit,
  input  logic              rxRun,
  input  logic              txRun,
  output csrStrobe_t        strobe
);

  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             hitMode, hitStatus, hitIntEn, hitRxBase, hitTxBase;
  logic             startReset;
  logic             open;

  always_comb begin
    hitMode   = wrEn && (regAddr == REG_MODE);
    hitStatus = wrEn && (regAddr == REG_STATUS);
    hitIntEn  = wrEn && (regAddr == REG_INTEN);
    hitRxBase = wrEn && (regAddr == REG_RXBASE);
    hitTxBase = wrEn && (regAddr == REG_TXBASE);
    startReset = hitMode && wrResetBit && !busyQ;
    open       = !busyQ && !startReset;
  end

  // Reset sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (startReset) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_LOAD;
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strobe.wrMode   = hitMode   && open;
    strobe.wrStatus = hitStatus && open;
    strobe.wrIntEn  = hitIntEn  && open;
    strobe.wrRxBase = hitRxBase && open && !rxRun;
    strobe.wrTxBase = hitTxBase && open && !txRun;
    strobe.clear    = startReset || busyQ;
    strobe.busy     = busyQ;
  end

  // Independent length counter for the reset window
  logic [CNT_W:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyLen <= '0;
    else if (busyQ) busyLen <= busyLen + 1'b1;
    else            busyLen <= '0;
  end

  assert_reset_window_max_R2: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (busyLen < (CNT_W+1)'(RST_CYCLES)));

  assert_reset_window_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> ($past(busyLen) == (CNT_W+1)'(RST_CYCLES - 1)));

endmodule

// File: rtl/dma_csr_dp.sv
module dma_csr_dp
  import dma_csr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              rxRun,
  output logic              txRun,
  output logic [DATA_W-1:0] rxBase,
  output logic [DATA_W-1:0] txBase,
  output logic              irq
);

  logic [NUM_EVT-1:0] statusQ, statusNext;
  logic [NUM_EVT-1:0] intEnQ, intEnNext;
  logic               summaryQ;

  // Per-bit write-one-to-clear with event priority
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_comb begin
      statusNext[i] = evtPulse[i] |
                      (statusQ[i] & ~(strobe.wrStatus & wrData[i]));
    end
  end

  assign intEnNext = strobe.wrIntEn ? wrData[NUM_EVT-1:0] : intEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      intEnQ   <= '0;
      summaryQ <= 1'b0;
      rxRun    <= 1'b0;
      txRun    <= 1'b0;
      rxBase   <= '0;
      txBase   <= '0;
    end else if (strobe.clear) begin
      statusQ  <= '0;
      intEnQ   <= '0;
      summaryQ <= 1'b0;
      rxRun    <= 1'b0;
      txRun    <= 1'b0;
      rxBase   <= '0;
      txBase   <= '0;
    end else begin
      statusQ  <= statusNext;
      intEnQ   <= intEnNext;
      summaryQ <= |(statusNext & intEnNext);
      if (strobe.wrMode) begin
        rxRun <= wrData[BIT_RXRUN];
        txRun <= wrData[BIT_TXRUN];
      end
      if (strobe.wrRxBase) rxBase <= wrData;
      if (strobe.wrTxBase) txBase <= wrData;
    end
  end

  assign irq = summaryQ;

  always_comb begin
    rdData = '0;
    case (regAddr)
      REG_MODE: begin
        rdData[BIT_RESET] = strobe.busy;
        rdData[BIT_RXRUN] = rxRun;
        rdData[BIT_TXRUN] = txRun;
      end
      REG_STATUS: begin
        rdData[NUM_EVT-1:0] = statusQ;
        rdData[BIT_SUMMARY] = summaryQ;
      end
      REG_INTEN:  rdData[NUM_EVT-1:0] = intEnQ;
      REG_RXBASE: rdData = rxBase;
      REG_TXBASE: rdData = txBase;
      default:    rdData = '0;
    endcase
  end

  assert_event_captured_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && (evtPulse != '0)) |=> ((statusQ & $past(evtPulse)) == $past(evtPulse)));

  assert_set_only_by_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> ((statusQ & ~$past(statusQ) & ~$past(evtPulse)) == '0));

  assert_summary_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq == |(statusQ & intEnQ));

  assert_held_in_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busy |=> (statusQ == '0 && intEnQ == '0 && !rxRun && !txRun));

  assert_rxbase_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxRun && !strobe.clear) |=> $stable(rxBase));

  assert_txbase_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txRun && !strobe.clear) |=> $stable(txBase));

endmodule

// File: rtl/dma_csr.sv
module dma_csr
  import dma_csr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_EVT    = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [dma_csr_pkg::ADDR_W-1:0] regAddr,
  input  logic                       wrEn,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_EVT-1:0]         evtPulse,
  output logic                       irq,
  output logic                       engReset,
  output logic                       rxRun,
  output logic                       txRun,
  output logic [DATA_W-1:0]          rxBase,
  output logic [DATA_W-1:0]          txBase
);

  csrStrobe_t strobe;

  dma_csr_ctrl #(.RST_CYCLES(RST_CYCLES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .regAddr    (regAddr),
    .wrResetBit (wrData[BIT_RESET]),
    .rxRun      (rxRun),
    .txRun      (txRun),
    .strobe     (strobe)
  );

  dma_csr_dp #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regAddr  (regAddr),
    .wrData   (wrData),
    .evtPulse (evtPulse),
    .rdData   (rdData),
    .rxRun    (rxRun),
    .txRun    (txRun),
    .rxBase   (rxBase),
    .txBase   (txBase),
    .irq      (irq)
  );

  assign engReset = strobe.busy;

  assert_start_clears_outputs_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(engReset) |-> (!rxRun && !txRun && !irq));

endmodule

// File: tb/test_dma_csr.sv
module test_dma_csr;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int NUM_EVT = 6;
  localparam int RST_CYCLES = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [NUM_EVT-1:0] evtPulse = '0;
  logic irq, engReset, rxRun, txRun;
  logic [DATA_W-1:0] rxBase, txBase;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .RST_CYCLES(RST_CYCLES)) i_dma_csr (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evtPulse(evtPulse), .irq(irq), .engReset(engReset),
    .rxRun(rxRun), .txRun(txRun), .rxBase(rxBase), .txBase(txBase)
  );

  localparam logic [2:0] A_MODE = 3'd0, A_STAT = 3'd1, A_EN = 3'd2,
                         A_RXB = 3'd3, A_TXB = 3'd4;
  localparam logic [31:0] SUM = 32'h0001_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] v);
    @(negedge clk);
    evtPulse = v;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      doRead(3'(a), v);
      check("R1 register after reset", v, 32'h0);
    end
    check("R1 irq/engReset/run", {28'h0, irq, engReset, rxRun, txRun}, 32'h0);
  endtask

  task automatic t_run_bits();
    logic [31:0] v;
    doWrite(A_MODE, 32'h0000_0002);
    doRead(A_MODE, v);
    check("R4 rx run readback", v, 32'h0000_0002);
    check("R4 rxRun/txRun", {30'h0, rxRun, txRun}, 32'h2);
    doWrite(A_MODE, 32'h0000_2000);
    doRead(A_MODE, v);
    check("R4 tx run readback", v, 32'h0000_2000);
    check("R4 rxRun/txRun tx only", {30'h0, rxRun, txRun}, 32'h1);
    doWrite(A_MODE, 32'h0);
  endtask

  task automatic t_events_w1c();
    logic [31:0] v;
    pulse(6'b100101);
    doRead(A_STAT, v);
    check("R5 events latched", v, 32'h25);
    repeat (3) @(negedge clk);
    doRead(A_STAT, v);
    check("R5 events held", v, 32'h25);
    doWrite(A_STAT, 32'h0000_FFDA);
    doRead(A_STAT, v);
    check("R6 write 0 keeps bits", v, 32'h25);
    doWrite(A_STAT, 32'h0000_0004);
    doRead(A_STAT, v);
    check("R6 write 1 clears bit2", v, 32'h21);
    doWrite(A_STAT, 32'h21);
    doRead(A_STAT, v);
    check("R6 cleared all", v, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    pulse(6'b001000);
    @(negedge clk);
    regAddr = A_STAT; wrData = 32'h8; wrEn = 1'b1; evtPulse = 6'b001000;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evtPulse = '0;
    doRead(A_STAT, v);
    check("R7 event wins over clear", v, 32'h8);
    doWrite(A_STAT, 32'h8);
    doRead(A_STAT, v);
    check("R7 later clear works", v, 32'h0);
  endtask

  task automatic t_summary_irq();
    logic [31:0] v;
    doWrite(A_EN, 32'hFFFF_FFFF);
    doRead(A_EN, v);
    check("R9 enable width", v, 32'h3F);
    doWrite(A_EN, 32'h05);
    pulse(6'b000010);
    doRead(A_STAT, v);
    check("R8 disabled event no summary", v, 32'h02);
    check("R9 irq low for disabled", {31'h0, irq}, 32'h0);
    pulse(6'b000001);
    doRead(A_STAT, v);
    check("R8 summary set", v, SUM | 32'h03);
    check("R9 irq high", {31'h0, irq}, 32'h1);
    doWrite(A_STAT, SUM);
    doRead(A_STAT, v);
    check("R8 summary recomputed after bit16 write", v, SUM | 32'h03);
    doWrite(A_STAT, SUM | 32'h01);
    doRead(A_STAT, v);
    check("R8 summary drops with member", v, 32'h02);
    check("R9 irq drops", {31'h0, irq}, 32'h0);
    doWrite(A_EN, 32'h02);
    doRead(A_STAT, v);
    check("R8 enabling pending event", v, SUM | 32'h02);
    check("R9 irq after enable", {31'h0, irq}, 32'h1);
    doWrite(A_STAT, 32'h02);
    check("R9 irq after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_base_lock();
    logic [31:0] v;
    doWrite(A_RXB, 32'h0000_1000);
    doRead(A_RXB, v);
    check("R10 rx base write when stopped", v, 32'h0000_1000);
    check("R10 rxBase port", rxBase, 32'h0000_1000);
    doWrite(A_MODE, 32'h2);
    doWrite(A_RXB, 32'h0000_2000);
    doRead(A_RXB, v);
    check("R10 rx base locked when running", v, 32'h0000_1000);
    doWrite(A_TXB, 32'h0000_3000);
    check("R10 txBase port while tx stopped", txBase, 32'h0000_3000);
    doWrite(A_MODE, 32'h2000);
    doWrite(A_RXB, 32'h0000_4000);
    doWrite(A_TXB, 32'h0000_5000);
    check("R10 rxBase after rx stop", rxBase, 32'h0000_4000);
    check("R10 txBase locked", txBase, 32'h0000_3000);
    doWrite(A_MODE, 32'h0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    doWrite(A_EN, 32'h3F);
    pulse(6'b010001);
    doWrite(A_MODE, 32'h2002);
    check("R2 preset irq", {31'h0, irq}, 32'h1);
    // mode write starting reset also carries run bits: must be dropped
    doWrite(A_MODE, 32'h2003);
    for (int k = 0; k < RST_CYCLES; k++) begin
      regAddr = A_MODE; #1;
      check($sformatf("R2 busy cycle %0d", k), {30'h0, engReset, rdData[0]}, 32'h3);
      check("R3 run bits dropped", {30'h0, rxRun, txRun}, 32'h0);
      @(negedge clk);
    end
    regAddr = A_MODE; #1;
    check("R2 busy ends", {30'h0, engReset, rdData[0]}, 32'h0);
    for (int a = 0; a < 5; a++) begin
      doRead(3'(a), v);
      check("R2 registers cleared", v, 32'h0);
    end
  endtask

  task automatic t_writes_during_reset();
    logic [31:0] v;
    doWrite(A_MODE, 32'h1);
    doWrite(A_EN, 32'h3F);
    doWrite(A_RXB, 32'hAAAA_0000);
    doWrite(A_TXB, 32'hBBBB_0000);
    pulse(6'b111111);
    doWrite(A_MODE, 32'h2002);
    while (engReset) @(negedge clk);
    doRead(A_EN, v);
    check("R3 enable write ignored", v, 32'h0);
    doRead(A_STAT, v);
    check("R3 events not recorded", v, 32'h0);
    check("R3 bases unchanged", rxBase | txBase, 32'h0);
    check("R3 run bits unchanged", {30'h0, rxRun, txRun}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_run_bits();
    t_events_w1c();
    t_collision();
    t_summary_irq();
    t_base_lock();
    t_soft_reset();
    t_writes_during_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule